// File: doc/BRIEF.md
# Attention Request Vector Handler

This block sits on the master side of an 8-bit backplane and watches eight shared, active-low, open-drain attention lines. Boards pull these lines to ask the processor for service, which may be an interrupt of either kind or a DMA request. The block brings the lines into its clock domain, removes any that the local mask blocks, and picks the lowest-numbered line that is still pending. It then hands a request record to the local processor through a valid/ready stream.

Two response modes are chosen per request by a mode pin sampled when the request is captured. In implicit mode the record carries only the line number, and software polls the boards and clears the source itself. In explicit mode the block first runs a vector-fetch bus cycle with command code 011. It strobes the bus and waits for the slave's data acknowledge or transfer error. On an acknowledge it returns the byte read as the vector. On an error it returns a fault flag instead. Once a record is offered, its number stays frozen until the processor accepts it.

Stream rules: `rpt_valid` never depends on `rpt_ready` in the same cycle, and `rpt_ready` may be high before `rpt_valid`. While `rpt_valid` is high and `rpt_ready` is low, the record does not change. A record is taken at a rising clock edge where both are high. The bus response inputs are taken to be synchronous to `clk`.

Top module: `attn_vector_ctrl`

## Requirements
- R1: With the block idle and in implicit mode, a record becomes valid exactly three rising edges after an attention line goes low (two synchroniser stages plus the capture register). It is not valid after the second edge.
- R2: `rpt_num` is the index of the lowest-numbered line that is pending and unmasked. Line 0 has the highest priority. A line is pending when its input bit is 0.
- R3: A mask bit of 1 blocks the line with the same index. `mask_wr` high at a rising edge loads `mask_data`. After reset every mask bit is 1, so no line is reported.
- R4: While `rpt_valid` is high and `rpt_ready` is low, `rpt_valid`, `rpt_num`, `rpt_vec` and `rpt_fault` hold. In the cycle after an accepting edge, `rpt_valid` is low.
- R5: After a record is captured, a newly pending higher-priority line does not alter the reported number, and neither does a mask write. The next record, taken after acceptance, reflects them.
- R6: In implicit mode (`explicit_mode` = 0 when the request is captured), no bus cycle is run: `dstb_n` stays 1 and `bus_cm` stays 111. The record has `rpt_vec` = 0 and `rpt_fault` = 0.
- R7: In explicit mode, from the edge that captures the request until a response is seen, `dstb_n` is 0 and `bus_cm` is 011. `bus_cm` differs from 111 only while `dstb_n` is 0.
- R8: When `dack_n` is 0 (and `terr_n` is 1) during the strobe, `bus_data` is latched as the vector with `rpt_fault` = 0. The strobe goes high at that same edge.
- R9: When `terr_n` is 0 during the strobe, whatever the state of `dack_n`, the record has `rpt_fault` = 1 and `rpt_vec` = 0.
- R10: After a response, the record is offered only once `dack_n` and `terr_n` are both seen at 1. Until then `dstb_n` stays 1 and `rpt_valid` stays 0.
- R11: During reset, `rpt_valid` is 0, `dstb_n` is 1 and `bus_cm` is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| attn_n | input | 8 | Attention lines, active low |
| mask_wr | input | 1 | Load enable for the mask register |
| mask_data | input | 8 | New mask value, 1 blocks a line |
| explicit_mode | input | 1 | 1 runs a vector fetch, 0 reports the number only |
| dstb_n | output | 1 | Bus data strobe, active low |
| bus_cm | output | 3 | Bus command code, 011 during a vector fetch, else 111 |
| dack_n | input | 1 | Slave data acknowledge, active low |
| terr_n | input | 1 | Slave transfer error, active low |
| bus_data | input | 8 | Bus data byte read during the fetch |
| rpt_valid | output | 1 | Request record valid |
| rpt_ready | input | 1 | Processor accepts the record |
| rpt_num | output | 3 | Line number of the request |
| rpt_vec | output | 8 | Fetched vector, 0 in implicit mode or on fault |
| rpt_fault | output | 1 | Vector fetch ended in a transfer error |

## Verification
The encoder is driven with a set of line patterns paired with masks: single lines at both ends, all lines at once, scattered pairs, and masks that hide the low lines. These patterns separate a correct lowest-index choice from highest-index, first-masked or unmasked selection. Implicit and explicit requests are contrasted on the bus pins. For explicit requests, the slave answers with an acknowledge after wait states, holds the acknowledge late, and answers with an error that coincides with an acknowledge. This exposes a strobe released too early, a record offered before the bus is free, and a wrong precedence between error and acknowledge. A late higher-priority request and a mask write during a pending record show whether the frozen number truly holds.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam logic [2:0] CM_VECTOR = 3'b011;
  localparam logic [2:0] CM_PARK   = 3'b111;

  typedef enum logic [1:0] {CTL_IDLE, CTL_FETCH, CTL_REPORT} ctl_state_e;
  typedef enum logic [1:0] {FX_IDLE, FX_STROBE, FX_RELEASE} fx_state_e;
endpackage

// File: rtl/attn_sync.sv
module attn_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_n,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= req_n;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pend = ~stage_q[STAGES-1];
endmodule

// File: rtl/attn_prio.sv
module attn_prio #(
  parameter int N_LINES = 8,
  parameter int NUM_W   = 3
) (
  input  logic [N_LINES-1:0] pend,
  input  logic [N_LINES-1:0] mask,
  output logic               any,
  output logic [NUM_W-1:0]   num
);
  logic [N_LINES-1:0] eligible;

  always_comb begin
    eligible = pend & ~mask;
    any      = |eligible;
    num      = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) num = NUM_W'(i);
    end
  end
endmodule

// File: rtl/attn_fetch.sv
module attn_fetch
  import attn_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dack_n,
  input  logic             terr_n,
  input  logic [VEC_W-1:0] bus_data,
  output logic             dstb_n,
  output logic [2:0]       cm,
  output logic             done,
  output logic [VEC_W-1:0] vec,
  output logic             fault
);
  fx_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FX_IDLE;
      vec   <= '0;
      fault <= 1'b0;
    end else begin
      unique case (st_q)
        FX_IDLE: if (start) st_q <= FX_STROBE;
        FX_STROBE: begin
          if (!terr_n) begin
            vec   <= '0;
            fault <= 1'b1;
            st_q  <= FX_RELEASE;
          end else if (!dack_n) begin
            vec   <= bus_data;
            fault <= 1'b0;
            st_q  <= FX_RELEASE;
          end
        end
        FX_RELEASE: if (dack_n && terr_n) st_q <= FX_IDLE;
        default: st_q <= FX_IDLE;
      endcase
    end
  end

  assign dstb_n = (st_q != FX_STROBE);
  assign cm     = (st_q == FX_STROBE) ? CM_VECTOR : CM_PARK;
  assign done   = (st_q == FX_RELEASE) && dack_n && terr_n;
endmodule

// File: rtl/attn_vector_ctrl.sv
module attn_vector_ctrl
  import attn_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N_LINES-1:0]                      attn_n,
  input  logic                                    mask_wr,
  input  logic [N_LINES-1:0]                      mask_data,
  input  logic                                    explicit_mode,
  output logic                                    dstb_n,
  output logic [2:0]                              bus_cm,
  input  logic                                    dack_n,
  input  logic                                    terr_n,
  input  logic [VEC_W-1:0]                        bus_data,
  output logic                                    rpt_valid,
  input  logic                                    rpt_ready,
  output logic [((N_LINES>1)?$clog2(N_LINES):1)-1:0] rpt_num,
  output logic [VEC_W-1:0]                        rpt_vec,
  output logic                                    rpt_fault
);
  localparam int NUM_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] mask_q;
  logic               enc_any;
  logic [NUM_W-1:0]   enc_num;
  logic               fx_start, fx_done, fx_fault;
  logic [VEC_W-1:0]   fx_vec;

  ctl_state_e         st_q;
  logic [NUM_W-1:0]   num_q;
  logic [VEC_W-1:0]   vec_q;
  logic               fault_q;

  attn_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (attn_n),
    .pend  (pend)
  );

  attn_prio #(.N_LINES(N_LINES), .NUM_W(NUM_W)) u_prio (
    .pend (pend),
    .mask (mask_q),
    .any  (enc_any),
    .num  (enc_num)
  );

  assign fx_start = (st_q == CTL_IDLE) && enc_any && explicit_mode;

  attn_fetch #(.VEC_W(VEC_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fx_start),
    .dack_n   (dack_n),
    .terr_n   (terr_n),
    .bus_data (bus_data),
    .dstb_n   (dstb_n),
    .cm       (bus_cm),
    .done     (fx_done),
    .vec      (fx_vec),
    .fault    (fx_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_wr) begin
      mask_q <= mask_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CTL_IDLE;
      num_q   <= '0;
      vec_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        CTL_IDLE: begin
          if (enc_any) begin
            num_q   <= enc_num;
            vec_q   <= '0;
            fault_q <= 1'b0;
            st_q    <= explicit_mode ? CTL_FETCH : CTL_REPORT;
          end
        end
        CTL_FETCH: begin
          if (fx_done) begin
            vec_q   <= fx_vec;
            fault_q <= fx_fault;
            st_q    <= CTL_REPORT;
          end
        end
        CTL_REPORT: if (rpt_ready) st_q <= CTL_IDLE;
        default: st_q <= CTL_IDLE;
      endcase
    end
  end

  assign rpt_valid = (st_q == CTL_REPORT);
  assign rpt_num   = num_q;
  assign rpt_vec   = vec_q;
  assign rpt_fault = fault_q;
endmodule

// File: rtl/attn_vector_chk.sv
module attn_vector_chk #(
  parameter int NUM_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dstb_n,
  input logic [2:0]       bus_cm,
  input logic             dack_n,
  input logic             terr_n,
  input logic             rpt_valid,
  input logic             rpt_ready,
  input logic [NUM_W-1:0] rpt_num,
  input logic [VEC_W-1:0] rpt_vec,
  input logic             rpt_fault
);
  AST_CM_ONLY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cm != 3'b111) |-> (!dstb_n && bus_cm == 3'b011)); // R7

  AST_STROBE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dstb_n && dack_n && terr_n) |=> !dstb_n); // R7

  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dstb_n && (!dack_n || !terr_n)) |=> dstb_n); // R8

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_num) &&
                                   $stable(rpt_vec) && $stable(rpt_fault))); // R4

  AST_RECORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_ready) |=> !rpt_valid); // R4

  AST_FAULT_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_fault) |-> (rpt_vec == '0)); // R9

  AST_NO_STROBE_IN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> dstb_n); // R10
endmodule

bind attn_vector_ctrl attn_vector_chk #(.NUM_W(NUM_W), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dstb_n    (dstb_n),
  .bus_cm    (bus_cm),
  .dack_n    (dack_n),
  .terr_n    (terr_n),
  .rpt_valid (rpt_valid),
  .rpt_ready (rpt_ready),
  .rpt_num   (rpt_num),
  .rpt_vec   (rpt_vec),
  .rpt_fault (rpt_fault)
);

// File: tb/sim_attn_vector_ctrl.sv
module sim_attn_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] attn_n = 8'hFF;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_data = 8'h00;
  logic       explicit_mode = 1'b0;
  logic       dstb_n;
  logic [2:0] bus_cm;
  logic       dack_n = 1'b1;
  logic       terr_n = 1'b1;
  logic [7:0] bus_data = 8'h00;
  logic       rpt_valid;
  logic       rpt_ready = 1'b0;
  logic [2:0] rpt_num;
  logic [7:0] rpt_vec;
  logic       rpt_fault;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  attn_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .mask_wr(mask_wr),
    .mask_data(mask_data), .explicit_mode(explicit_mode), .dstb_n(dstb_n),
    .bus_cm(bus_cm), .dack_n(dack_n), .terr_n(terr_n), .bus_data(bus_data),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_num(rpt_num),
    .rpt_vec(rpt_vec), .rpt_fault(rpt_fault)
  );

  // {mask, attn_n, expected number}
  localparam logic [18:0] VEC_TBL [8] = '{
    {8'h00, 8'hFE, 3'd0},
    {8'h00, 8'h7F, 3'd7},
    {8'h00, 8'h00, 3'd0},
    {8'h00, 8'h5F, 3'd5},
    {8'h01, 8'h00, 3'd1},
    {8'h0F, 8'hE6, 3'd4},
    {8'h7F, 8'h00, 3'd7},
    {8'hF0, 8'h3D, 3'd1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_mask(input logic [7:0] m);
    mask_data = m;
    mask_wr = 1'b1;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic accept();
    rpt_ready = 1'b1;
    tick();
    rpt_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R11 reset state
    tick();
    chk("R11 valid", rpt_valid, 0);
    chk("R11 dstb_n", dstb_n, 1);
    chk("R11 cm", bus_cm, 3'b111);
    rst_n = 1'b1;
    tick();

    // R3 all lines masked after reset
    attn_n = 8'h00;
    for (int i = 0; i < 6; i++) tick();
    chk("R3 reset mask blocks", rpt_valid, 0);
    attn_n = 8'hFF;
    for (int i = 0; i < 3; i++) tick();

    // Table walk in implicit mode: R1 R2 R3 R6
    explicit_mode = 1'b0;
    for (int k = 0; k < 8; k++) begin
      load_mask(VEC_TBL[k][18:11]);
      attn_n = VEC_TBL[k][10:3];
      tick();
      tick();
      chk("R1 not yet valid", rpt_valid, 0);
      tick();
      chk("R1 valid at third edge", rpt_valid, 1);
      chk("R2 number", rpt_num, VEC_TBL[k][2:0]);
      chk("R6 no strobe", dstb_n, 1);
      chk("R6 cm parked", bus_cm, 3'b111);
      chk("R6 vec zero", rpt_vec, 0);
      chk("R6 fault zero", rpt_fault, 0);
      attn_n = 8'hFF;
      for (int i = 0; i < 3; i++) tick();
      chk("R4 held while not ready", rpt_num, VEC_TBL[k][2:0]);
      accept();
      chk("R4 drops after accept", rpt_valid, 0);
      tick();
    end

    // R3 mask write blocks a lone line
    load_mask(8'h10);
    attn_n = 8'hEF;
    for (int i = 0; i < 5; i++) tick();
    chk("R3 masked line silent", rpt_valid, 0);
    attn_n = 8'hFF;
    for (int i = 0; i < 3; i++) tick();

    // R5 frozen number
    load_mask(8'h00);
    attn_n = 8'hF7;
    for (int i = 0; i < 3; i++) tick();
    chk("R5 first number", rpt_num, 3);
    attn_n = 8'hF6;
    load_mask(8'h08);
    for (int i = 0; i < 3; i++) tick();
    chk("R5 still valid", rpt_valid, 1);
    chk("R5 number frozen", rpt_num, 3);
    accept();
    chk("R4 gap after accept", rpt_valid, 0);
    tick();
    chk("R5 next record valid", rpt_valid, 1);
    chk("R5 next number", rpt_num, 0);
    attn_n = 8'hFF;
    for (int i = 0; i < 3; i++) tick();
    accept();
    load_mask(8'h00);
    tick();

    // Explicit fetch with wait states and late acknowledge release
    explicit_mode = 1'b1;
    attn_n = 8'hFB;
    for (int i = 0; i < 3; i++) tick();
    chk("R7 strobe low", dstb_n, 0);
    chk("R7 cm vector", bus_cm, 3'b011);
    tick();
    tick();
    chk("R7 strobe held in wait", dstb_n, 0);
    chk("R7 cm held in wait", bus_cm, 3'b011);
    chk("R7 no record yet", rpt_valid, 0);
    bus_data = 8'hA5;
    dack_n = 1'b0;
    tick();
    chk("R8 strobe released", dstb_n, 1);
    chk("R8 cm parked", bus_cm, 3'b111);
    bus_data = 8'h00;
    tick();
    tick();
    chk("R10 waits for ack release", rpt_valid, 0);
    chk("R10 strobe stays high", dstb_n, 1);
    dack_n = 1'b1;
    attn_n = 8'hFF;
    tick();
    chk("R10 record after release", rpt_valid, 1);
    chk("R8 number", rpt_num, 2);
    chk("R8 vector", rpt_vec, 8'hA5);
    chk("R8 fault clear", rpt_fault, 0);
    for (int i = 0; i < 3; i++) tick();
    chk("R4 vector held", rpt_vec, 8'hA5);
    chk("R4 valid held", rpt_valid, 1);
    accept();
    chk("R4 drop after fetch record", rpt_valid, 0);
    tick();

    // Explicit fetch ending in error together with acknowledge
    attn_n = 8'hEF;
    for (int i = 0; i < 3; i++) tick();
    chk("R7 strobe low second", dstb_n, 0);
    bus_data = 8'h3C;
    dack_n = 1'b0;
    terr_n = 1'b0;
    tick();
    chk("R8 strobe released on error", dstb_n, 1);
    dack_n = 1'b1;
    terr_n = 1'b1;
    attn_n = 8'hFF;
    tick();
    chk("R9 record valid", rpt_valid, 1);
    chk("R9 number", rpt_num, 4);
    chk("R9 fault set", rpt_fault, 1);
    chk("R9 vector zero", rpt_vec, 0);
    tick();
    tick();
    accept();
    chk("R4 drop after fault record", rpt_valid, 0);
    tick();

    finish_run();
  end
endmodule